// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divisor settings of one integer-N PLL without ever exposing downstream logic to an unlocked clock. A request carries three divisors: the reference divider `nr`, the feedback multiplier `nf` and the output divider `no`. The sequencer first checks that the request gives a legal VCO and output frequency. If it does, the block parks the PLL output on the oscillator bypass and asserts the PLL reset. It then writes the encoded divisor and loop-bandwidth fields and keeps reset asserted for a timed hold. After releasing reset it waits for the lock bit of this PLL, and only then switches the output back to normal mode.

The analog PLL is not part of the block. Its control words are driven out as register-style output words, and its lock indication comes back in on a shared status word. A combinational rate readback reports the frequency that the current mode and divisor fields imply.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and the divisors steady until that edge. While a sequence runs, `req_ready` stays low and any request presented is neither taken nor remembered.

Top module: `pll_reprog_seq`

## Requirements
- R1: `req_ready` is high exactly when no sequence is running. A request presented while busy is not taken, and it has no effect on the sequence in progress or on the error flags.
- R2: Mode codes are slow = 0, normal = 1, deep = 2. On the edge that takes a legal request, the mode becomes slow, and this happens before the reset bit is set.
- R3: The PLL reset is bit 5 of control word 3. It is set before any divisor field changes. It stays set for at least HOLD_US × CLK_MHZ cycles and is clear when the sequence ends.
- R4: Control word 0 carries `nr-1` in bits [13:8] and `no-1` in bits [3:0]. Control word 1 carries `nf-1` in bits [12:0]. All other bits of these words are zero.
- R5: Control word 2 carries floor(`nf`/2) − 1 in bits [11:0], and its other bits are zero.
- R6: A request is rejected if any of the following holds: `nr` is outside 1..64; `nf` is outside 2..8192; `no` is outside 1..16; `no` is odd and greater than 1; 24 MHz × `nf`/`nr` lies outside 440..2200 MHz; or that VCO frequency divided by `no` lies outside 27.5..2200 MHz. A rejection raises `err_reject`, starts no sequence, and leaves the mode and all control words unchanged.
- R7: Only status bit 5 + PLL_SEL counts as lock, and it is sampled only after reset has been released. The cycle after lock is seen, the mode becomes normal.
- R8: If lock does not arrive within LOCK_TIMEOUT cycles of the reset release, `err_timeout` is raised, the mode stays slow and the sequence ends.
- R9: The rate readback is 24,000,000 in slow mode and (24·nf / (nr·no), truncated) × 1,000,000 in normal mode, with the divisors decoded from the control fields. Any other mode code reads 32768.
- R10: `busy` rises on the edge that takes a legal request. It falls on the same edge that the mode becomes normal or that the timeout is flagged.
- R11: After reset the outputs are: mode slow, all control words zero, `busy` low, `req_ready` high, both error flags low, and rate 24,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Divisor request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_nr | input | 7 | Requested reference divider (1..64) |
| req_nf | input | 14 | Requested feedback multiplier (2..8192) |
| req_no | input | 5 | Requested output divider (1 or even, up to 16) |
| pll_status | input | 16 | Shared status word, lock bits at 5..9 |
| busy | output | 1 | Sequence in progress |
| pll_mode | output | 2 | Output mode: 0 slow, 1 normal, 2 deep |
| ctl_word0 | output | 16 | Reference and output divider fields |
| ctl_word1 | output | 16 | Feedback divider field |
| ctl_word2 | output | 16 | Bandwidth adjust field |
| ctl_word3 | output | 16 | PLL reset in bit 5 |
| err_reject | output | 1 | Last request was illegal |
| err_timeout | output | 1 | Last sequence did not see lock |
| rate_hz | output | 32 | Rate implied by mode and divider fields |

## Verification
The bench holds the lock bit high through the whole reset hold. A design that samples lock early would return to normal with reset still set, or would cut the hold short. It also drives lock on the neighbouring status bits while the bit for this PLL stays low. A design that watches the wrong bit would finish instead of timing out. The rejection cases sit just outside the VCO window, at an odd output divider and at a zero reference divider. A checker that is too loose would reprogram the fields and leave them different from the values before the request. The accepted cases include `nr` = 64, `no` = 16 and an odd `nf`. These expose a wrong field position, a wrong width, or a bandwidth field rounded instead of floored. A request held high during a running sequence catches a design that lets it in once the sequence ends or that corrupts the error flags.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_ON,
    ST_PROG,
    ST_HOLD,
    ST_LOCK_WAIT
  } seq_state_e;

  localparam int RST_BIT   = 5;
  localparam int LOCK_BASE = 5;
  localparam int REF_LSB   = 8;

  localparam longint VCO_MIN_KHZ = 440000;
  localparam longint VCO_MAX_KHZ = 2200000;
  localparam longint OUT_MIN_KHZ = 27500;
  localparam longint OUT_MAX_KHZ = 2200000;
  localparam longint DEEP_HZ     = 32768;
endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int OSC_KHZ = 24000,
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4
) (
  input  logic [NR_W:0] nr,
  input  logic [NF_W:0] nf,
  input  logic [NO_W:0] no,
  output logic          ok
);
  import pll_seq_pkg::*;

  localparam longint NR_MAX = longint'(1) << NR_W;
  localparam longint NF_MAX = longint'(1) << NF_W;
  localparam longint NO_MAX = longint'(1) << NO_W;

  logic [63:0] fin, nr_l, ratio;
  logic        range_ok, no_form_ok, vco_ok, out_ok;

  always_comb begin
    nr_l       = 64'(nr);
    ratio      = 64'(nr) * 64'(no);
    fin        = 64'(OSC_KHZ) * 64'(nf);
    range_ok   = (nr != '0) && (64'(nr) <= NR_MAX) &&
                 (64'(nf) >= 64'd2) && (64'(nf) <= NF_MAX) &&
                 (no != '0) && (64'(no) <= NO_MAX);
    no_form_ok = (no == (NO_W+1)'(1)) || !no[0];
    vco_ok     = (fin >= 64'(VCO_MIN_KHZ) * nr_l) && (fin <= 64'(VCO_MAX_KHZ) * nr_l);
    out_ok     = (fin >= 64'(OUT_MIN_KHZ) * ratio) && (fin <= 64'(OUT_MAX_KHZ) * ratio);
    ok         = range_ok && no_form_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int OSC_KHZ = 24000,
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4
) (
  input  pll_seq_pkg::pll_mode_e mode,
  input  logic [NR_W-1:0]        nr_enc,
  input  logic [NF_W-1:0]        nf_enc,
  input  logic [NO_W-1:0]        no_enc,
  output logic [31:0]            rate_hz
);
  import pll_seq_pkg::*;

  localparam longint OSC_MHZ = OSC_KHZ / 1000;

  logic [63:0] nr_v, nf_v, no_v, mhz;

  always_comb begin
    nr_v = 64'(nr_enc) + 64'd1;
    nf_v = 64'(nf_enc) + 64'd1;
    no_v = 64'(no_enc) + 64'd1;
    mhz  = (64'(OSC_MHZ) * nf_v) / (nr_v * no_v);
    unique case (mode)
      MODE_SLOW:   rate_hz = 32'(longint'(OSC_KHZ) * 1000);
      MODE_NORMAL: rate_hz = 32'(mhz * 64'd1000000);
      default:     rate_hz = 32'(DEEP_HZ);
    endcase
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm #(
  parameter int NR_W         = 6,
  parameter int NF_W         = 13,
  parameter int NO_W         = 4,
  parameter int BW_W         = 12,
  parameter int CW_W         = 16,
  parameter int HOLD_CYC     = 2500,
  parameter int LOCK_TIMEOUT = 100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_ok,
  input  logic [NR_W:0]          req_nr,
  input  logic [NF_W:0]          req_nf,
  input  logic [NO_W:0]          req_no,
  input  logic                   lock,
  output logic                   ready,
  output logic                   busy,
  output pll_seq_pkg::pll_mode_e mode,
  output logic [CW_W-1:0]        ctl0,
  output logic [CW_W-1:0]        ctl1,
  output logic [CW_W-1:0]        ctl2,
  output logic [CW_W-1:0]        ctl3,
  output logic                   err_reject,
  output logic                   err_timeout
);
  import pll_seq_pkg::*;

  localparam int CNT_MAX = (HOLD_CYC > LOCK_TIMEOUT) ? HOLD_CYC : LOCK_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [NR_W:0]   nr_q;
  logic [NF_W:0]   nf_q;
  logic [NO_W:0]   no_q;
  logic            pll_rst_q;
  logic [CW_W-1:0] enc0, enc1, enc2;

  always_comb begin
    enc0 = '0;
    enc0[pll_seq_pkg::REF_LSB +: NR_W] = NR_W'(nr_q - 1'b1);
    enc0[0 +: NO_W]                    = NO_W'(no_q - 1'b1);
    enc1 = '0;
    enc1[0 +: NF_W] = NF_W'(nf_q - 1'b1);
    enc2 = '0;
    enc2[0 +: BW_W] = BW_W'((nf_q >> 1) - 1'b1);
  end

  assign ready = (state == ST_IDLE);
  assign busy  = (state != ST_IDLE);
  assign ctl3  = CW_W'(pll_rst_q) << RST_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      mode        <= MODE_SLOW;
      nr_q        <= '0;
      nf_q        <= '0;
      no_q        <= '0;
      pll_rst_q   <= 1'b0;
      ctl0        <= '0;
      ctl1        <= '0;
      ctl2        <= '0;
      err_reject  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          err_reject  <= !req_ok;
          err_timeout <= 1'b0;
          if (req_ok) begin
            mode  <= MODE_SLOW;
            nr_q  <= req_nr;
            nf_q  <= req_nf;
            no_q  <= req_no;
            state <= ST_RST_ON;
          end
        end
        ST_RST_ON: begin
          pll_rst_q <= 1'b1;
          state     <= ST_PROG;
        end
        ST_PROG: begin
          ctl0  <= enc0;
          ctl1  <= enc1;
          ctl2  <= enc2;
          cnt   <= '0;
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) begin
            pll_rst_q <= 1'b0;
            cnt       <= '0;
            state     <= ST_LOCK_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOCK_WAIT: begin
          if (lock) begin
            mode  <= MODE_NORMAL;
            state <= ST_IDLE;
          end else if (cnt == CNT_W'(LOCK_TIMEOUT - 1)) begin
            err_timeout <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int OSC_KHZ      = 24000,
  parameter int CLK_MHZ      = 250,
  parameter int HOLD_US      = 10,
  parameter int LOCK_TIMEOUT = 100000,
  parameter int PLL_SEL      = 0,
  parameter int NR_W         = 6,
  parameter int NF_W         = 13,
  parameter int NO_W         = 4,
  parameter int BW_W         = 12,
  parameter int CW_W         = 16,
  parameter int STAT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NR_W:0]     req_nr,
  input  logic [NF_W:0]     req_nf,
  input  logic [NO_W:0]     req_no,
  input  logic [STAT_W-1:0] pll_status,
  output logic              busy,
  output logic [1:0]        pll_mode,
  output logic [CW_W-1:0]   ctl_word0,
  output logic [CW_W-1:0]   ctl_word1,
  output logic [CW_W-1:0]   ctl_word2,
  output logic [CW_W-1:0]   ctl_word3,
  output logic              err_reject,
  output logic              err_timeout,
  output logic [31:0]       rate_hz
);
  import pll_seq_pkg::*;

  localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
  localparam int LOCK_IDX = LOCK_BASE + PLL_SEL;

  logic      req_ok;
  logic      lock_w;
  pll_mode_e mode_w;

  assign lock_w   = pll_status[LOCK_IDX];
  assign pll_mode = mode_w;

  pll_req_check #(
    .OSC_KHZ(OSC_KHZ), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)
  ) chk_req_i (
    .nr(req_nr), .nf(req_nf), .no(req_no), .ok(req_ok)
  );

  pll_seq_fsm #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .CW_W(CW_W),
    .HOLD_CYC(HOLD_CYC), .LOCK_TIMEOUT(LOCK_TIMEOUT)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ok(req_ok),
    .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .lock(lock_w),
    .ready(req_ready), .busy(busy), .mode(mode_w),
    .ctl0(ctl_word0), .ctl1(ctl_word1), .ctl2(ctl_word2), .ctl3(ctl_word3),
    .err_reject(err_reject), .err_timeout(err_timeout)
  );

  pll_rate_calc #(
    .OSC_KHZ(OSC_KHZ), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)
  ) rate_i (
    .mode(mode_w),
    .nr_enc(ctl_word0[REF_LSB +: NR_W]),
    .nf_enc(ctl_word1[0 +: NF_W]),
    .no_enc(ctl_word0[0 +: NO_W]),
    .rate_hz(rate_hz)
  );
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
  parameter int HOLD_CYC = 2500,
  parameter int CW_W     = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            busy,
  input logic [1:0]      pll_mode,
  input logic [CW_W-1:0] ctl_word0,
  input logic [CW_W-1:0] ctl_word1,
  input logic [CW_W-1:0] ctl_word2,
  input logic [CW_W-1:0] ctl_word3,
  input logic            lock_w,
  input logic            err_reject,
  input logic            err_timeout
);
  import pll_seq_pkg::*;

  logic       prst;
  logic [31:0] hold_cnt;

  assign prst = ctl_word3[RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_cnt <= '0;
    else if (prst) hold_cnt <= hold_cnt + 1;
    else           hold_cnt <= '0;
  end

  assert_slow_before_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prst) |-> pll_mode == 2'(MODE_SLOW));

  assert_fields_need_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prst |=> $stable(ctl_word0) && $stable(ctl_word1) && $stable(ctl_word2));

  assert_hold_long_enough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prst) |-> hold_cnt >= 32'(HOLD_CYC));

  assert_normal_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mode == 2'(MODE_NORMAL) && $past(pll_mode) != 2'(MODE_NORMAL)) |-> ($past(lock_w) && !prst));

  assert_reject_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_reject |-> !busy);

  assert_timeout_stays_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (pll_mode == 2'(MODE_SLOW) && !busy));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pll_mode == 2'(MODE_NORMAL) || err_timeout));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.HOLD_CYC(HOLD_CYC), .CW_W(CW_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .pll_mode(pll_mode),
  .ctl_word0(ctl_word0), .ctl_word1(ctl_word1), .ctl_word2(ctl_word2),
  .ctl_word3(ctl_word3), .lock_w(lock_w),
  .err_reject(err_reject), .err_timeout(err_timeout)
);

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;
  localparam int HOLD = 250;
  localparam int TMO  = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_nr = '0;
  logic [13:0] req_nf = '0;
  logic [4:0]  req_no = '0;
  logic [15:0] pll_status = '0;
  logic        busy;
  logic [1:0]  pll_mode;
  logic [15:0] ctl_word0, ctl_word1, ctl_word2, ctl_word3;
  logic        err_reject, err_timeout;
  logic [31:0] rate_hz;

  always #2 clk = ~clk;

  pll_reprog_seq #(.HOLD_US(1), .CLK_MHZ(250), .LOCK_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .pll_status(pll_status),
    .busy(busy), .pll_mode(pll_mode),
    .ctl_word0(ctl_word0), .ctl_word1(ctl_word1), .ctl_word2(ctl_word2),
    .ctl_word3(ctl_word3), .err_reject(err_reject), .err_timeout(err_timeout),
    .rate_hz(rate_hz)
  );

  typedef struct packed {
    logic [15:0] c0, c1, c2, c3;
    logic [1:0]  md;
    logic [31:0] rate;
    logic        rej, tmo;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_e;
  int   checks = 0, fails = 0;
  int   n_iss = 0, n_done = 0;
  int   lock_mode = 0;
  int   lk_cnt = 20;
  event acc_ev;

  task automatic check(string what, longint got, longint expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, expv);
    end
  endtask

  function automatic bit req_good(longint nr, longint nf, longint no);
    longint fin = 24000 * nf;
    return nr >= 1 && nr <= 64 && nf >= 2 && nf <= 8192 && no >= 1 && no <= 16 &&
           (no == 1 || no % 2 == 0) &&
           fin >= 440000 * nr && fin <= 2200000 * nr &&
           fin >= 27500 * nr * no && fin <= 2200000 * nr * no;
  endfunction

  // lock model: bit 5 rises 20 cycles after the PLL reset is released
  initial forever begin
    @(negedge clk);
    case (lock_mode)
      1: pll_status = 16'h03C0;
      2: pll_status = 16'h0020;
      default: begin
        if (ctl_word3[5]) begin lk_cnt = 0; pll_status = 16'h0000; end
        else if (lk_cnt < 20) lk_cnt++;
        else pll_status = 16'h0020;
      end
    endcase
  end

  task automatic issue(int nr, int nf, int no);
    exp_t e;
    if (req_good(nr, nf, no)) begin
      e.c0 = 16'(((nr - 1) << 8) | (no - 1));
      e.c1 = 16'(nf - 1);
      e.c2 = 16'(nf / 2 - 1);
      e.c3 = 16'h0;
      e.rej = 1'b0;
      if (lock_mode == 1) begin
        e.md = 2'd0; e.rate = 32'd24000000; e.tmo = 1'b1;
      end else begin
        e.md = 2'd1; e.rate = 32'(longint'((24 * nf) / (nr * no)) * 1000000); e.tmo = 1'b0;
      end
    end else begin
      e = last_e;
      e.rej = 1'b1;
      e.tmo = 1'b0;
    end
    last_e = e;
    exp_q.push_back(e);
    @(negedge clk);
    req_nr = 7'(nr); req_nf = 14'(nf); req_no = 5'(no);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_iss++;
    -> acc_ev;
  endtask

  task automatic wait_done();
    wait (n_done == n_iss);
    @(negedge clk);
  endtask

  task automatic run(int nr, int nf, int no);
    issue(nr, nf, no);
    wait_done();
  endtask

  // monitor: pops the expected item for each taken request
  initial begin
    logic [15:0] p0, p1, p2;
    p0 = '0; p1 = '0; p2 = '0;
    forever begin
      exp_t e;
      int   rc;
      bit   seen;
      @(acc_ev);
      e = exp_q.pop_front();
      if (busy) begin
        check("R2 mode slow right after acceptance", pll_mode, 0);
        check("R1 ready low while busy", req_ready, 0);
        rc = 0; seen = 0;
        while (busy) begin
          if (ctl_word3[5] && !seen) begin
            seen = 1;
            check("R3 word0 unchanged when reset first set", ctl_word0, p0);
            check("R3 word1 unchanged when reset first set", ctl_word1, p1);
            check("R3 word2 unchanged when reset first set", ctl_word2, p2);
            check("R2 mode slow when reset set", pll_mode, 0);
          end
          if (ctl_word3[5]) rc++;
          @(negedge clk);
        end
        check("R3 reset hold long enough", (rc >= HOLD) ? 1 : 0, 1);
      end
      check("R4 word0 fields", ctl_word0, e.c0);
      check("R4 word1 field", ctl_word1, e.c1);
      check("R5 bandwidth field", ctl_word2, e.c2);
      check("R3 reset clear at end", ctl_word3, e.c3);
      check("R7 mode at end", pll_mode, e.md);
      check("R9 rate readback", rate_hz, e.rate);
      check("R6 reject flag", err_reject, e.rej);
      check("R8 timeout flag", err_timeout, e.tmo);
      check("R10 busy low at end", busy, 0);
      p0 = ctl_word0; p1 = ctl_word1; p2 = ctl_word2;
      n_done++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    last_e = '{c0: 16'h0, c1: 16'h0, c2: 16'h0, c3: 16'h0, md: 2'd0,
               rate: 32'd24000000, rej: 1'b0, tmo: 1'b0};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 mode", pll_mode, 0);
    check("R11 word0", ctl_word0, 0);
    check("R11 word1", ctl_word1, 0);
    check("R11 word2", ctl_word2, 0);
    check("R11 word3", ctl_word3, 0);
    check("R11 busy", busy, 0);
    check("R11 ready", req_ready, 1);
    check("R11 errors", {err_reject, err_timeout}, 0);
    check("R11 rate", rate_hz, 24000000);

    run(1, 75, 1);     // 1800 MHz VCO, no divider
    run(2, 100, 2);    // 600 MHz out
    run(9, 400, 2);    // truncated rate 533 MHz
    run(64, 2000, 1);  // largest reference divider
    run(1, 90, 16);    // largest output divider
    run(1, 50, 3);     // R6 odd output divider
    run(1, 18, 1);     // R6 VCO 432 MHz, below window
    run(1, 92, 1);     // R6 VCO 2208 MHz, above window
    run(0, 50, 1);     // R6 zero reference divider
    lock_mode = 2;     // R7 lock high through the whole hold
    run(1, 41, 4);     // odd nf, bandwidth floors
    lock_mode = 1;     // R7/R8 neighbours locked, own bit low
    run(4, 100, 2);
    lock_mode = 0;
    lk_cnt = 20;
    // R1 request held while busy is not taken
    issue(2, 100, 2);
    @(negedge clk);
    req_nr = 7'd0; req_nf = 14'd1; req_no = 5'd3;
    req_valid = 1'b1;
    repeat (40) @(negedge clk);
    check("R1 ready low with request pending", req_ready, 0);
    req_valid = 1'b0;
    wait_done();
    check("R1 no reject from request seen while busy", err_reject, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule